// File: doc/BRIEF.md
# Relative Branch Resolver

This block settles a relative branch for a processor with a 16-bit program counter. When the decoder pulses `resolve_i`, the block samples several values. The first is the program counter, which already points past the branch instruction. The others are a displacement, a condition selector, a long-form select and the current flag state. The flag state is held as the last result: a sign-carrying byte, a zero-test value, and the overflow and carry bits.

One cycle later the block presents three registered results, together with a one-cycle `valid_o` pulse:
- whether the branch is taken;
- the next program counter;
- how many extra bus cycles the branch costs.

A short branch adds a sign-extended 8-bit displacement. The cost is zero when the branch is not taken, one when it is taken within the same 256-byte page, and two when the target leaves that page. The long form always branches, using a signed 16-bit displacement, and its cost is fixed by the instruction, so it reports no extra cycles. All address arithmetic wraps within 16 bits and never touches any bank register.

Top module: `br_resolve_unit`

## Requirements
- R1: While `rst` is high, and after it, until the first strobe, `valid_o`, `taken_o`, `target_o` and `penalty_o` are all zero.
- R2: `valid_o` is high in exactly the cycle after each cycle in which `resolve_i` is high, and low otherwise; all results are registered.
- R3: A short branch that is taken targets `pc_i` plus the sign extension of `disp_i[7:0]`; `disp_i[15:8]` has no effect on a short branch.
- R4: A short branch that is not taken reports `taken_o`=0, `target_o`=`pc_i` and `penalty_o`=0.
- R5: A short branch that is taken and has `target_o[15:8]` equal to `pc_i[15:8]` reports `penalty_o`=1.
- R6: A short branch that is taken and has `target_o[15:8]` different from `pc_i[15:8]` reports `penalty_o`=2.
- R7: Selector codes 0 to 5 test the flags as follows: 0 takes when bit 7 of `n_result_i` is 0, and 1 when it is 1; 2 takes when `v_i`=0, and 3 when `v_i`=1; 4 takes when `c_i`=0, and 5 when `c_i`=1.
- R8: Selector code 6 (not equal) takes when `z_result_i` is nonzero in any bit, and code 7 (equal) takes when it is zero.
- R9: Selector code 8 always takes; codes 9 to 15 never take.
- R10: With `long_i`=1, the selector is ignored: `taken_o`=1, `target_o`=`pc_i`+`disp_i` modulo 65536, and `penalty_o`=0.
- R11: Between strobes, `taken_o`, `target_o` and `penalty_o` hold their values whatever the inputs do.
- R12: Target arithmetic wraps modulo 65536 in both directions, and a wrap counts as a page change for a short branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resolve_i | input | 1 | Strobe: sample the inputs and resolve |
| long_i | input | 1 | Select the unconditional 16-bit displacement form |
| cond_i | input | 4 | Condition selector (codes in R7 to R9) |
| pc_i | input | 16 | Program counter past the instruction |
| disp_i | input | 16 | Displacement; the short form uses bits 7:0 |
| n_result_i | input | 8 | Stored result byte; bit 7 is the sign |
| z_result_i | input | 16 | Stored result value for the zero test |
| v_i | input | 1 | Overflow flag |
| c_i | input | 1 | Carry flag |
| valid_o | output | 1 | One-cycle pulse: results updated |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |
| penalty_o | output | 2 | Extra cycles: 0, 1 or 2 |

## Verification
Every result is due exactly one clock after the cycle in which `resolve_i` was sampled high, because a single register stage lies between the inputs and the outputs. The bench drives each strobe on a falling edge and drops it on the next falling edge. It compares all results at that second falling edge, half a period after the capturing rising edge. One more falling edge later it confirms that `valid_o` has returned low. Before that check it scrambles the inputs, so the held results also show the hold behaviour. The reset values are read on a falling edge while reset is high, and again after reset has been released and before the first strobe.

// File: rtl/br_pkg.sv
package br_pkg;

    // Condition selector encoding
    typedef enum logic [3:0] {
        COND_SIGN_CLR = 4'd0,
        COND_SIGN_SET = 4'd1,
        COND_OVF_CLR  = 4'd2,
        COND_OVF_SET  = 4'd3,
        COND_CRY_CLR  = 4'd4,
        COND_CRY_SET  = 4'd5,
        COND_NONZERO  = 4'd6,
        COND_ZERO     = 4'd7,
        COND_ALWAYS   = 4'd8
    } cond_e;

    // Extra-cycle cost of a resolved branch
    typedef enum logic [1:0] {
        PEN_NONE  = 2'd0,
        PEN_TAKEN = 2'd1,
        PEN_CROSS = 2'd2
    } penalty_e;

    // Flag snapshot carried into the condition evaluator
    typedef struct packed {
        logic sign;
        logic ovf;
        logic cry;
        logic nonzero;
    } flags_t;

    // Sign bit of a stored result byte
    function automatic logic byte_is_negative(input logic [7:0] b);
        return b > 8'h7F;
    endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       take_o
);
    cond_e sel;
    assign sel = cond_e'(cond_i);

    // R7, R8, R9: selector decode
    always_comb begin
        case (sel)
            COND_SIGN_CLR: take_o = !flags_i.sign;
            COND_SIGN_SET: take_o =  flags_i.sign;
            COND_OVF_CLR:  take_o = !flags_i.ovf;
            COND_OVF_SET:  take_o =  flags_i.ovf;
            COND_CRY_CLR:  take_o = !flags_i.cry;
            COND_CRY_SET:  take_o =  flags_i.cry;
            COND_NONZERO:  take_o =  flags_i.nonzero;
            COND_ZERO:     take_o = !flags_i.nonzero;
            COND_ALWAYS:   take_o = 1'b1;
            default:       take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] disp_i,
    input  logic            long_i,
    input  logic            taken_i,
    output logic [PC_W-1:0] target_o
);
    logic [PC_W-1:0] short_ext;
    logic [PC_W-1:0] offset;
    logic [PC_W-1:0] sum;

    // R3: sign-extend the short displacement to the PC width
    generate
        if (SHORT_W < PC_W) begin : g_ext
            assign short_ext = {{(PC_W-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
        end else begin : g_full
            assign short_ext = disp_i;
        end
    endgenerate

    assign offset = long_i ? disp_i : short_ext;
    assign sum    = pc_i + offset;          // R12: wraps at the PC width
    assign target_o = taken_i ? sum : pc_i; // R4: fall through when not taken
endmodule

// File: rtl/br_page_cmp.sv
module br_page_cmp
    import br_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int PAGE_BITS = 8
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            taken_i,
    input  logic            long_i,
    output penalty_e        penalty_o
);
    localparam int HI_W = PC_W - PAGE_BITS;

    logic [HI_W-1:0] pc_page;
    logic [HI_W-1:0] tgt_page;
    assign pc_page  = pc_i[PC_W-1:PAGE_BITS];
    assign tgt_page = target_i[PC_W-1:PAGE_BITS];

    // R4, R5, R6, R10
    always_comb begin
        if (!taken_i || long_i)        penalty_o = PEN_NONE;
        else if (pc_page == tgt_page)  penalty_o = PEN_TAKEN;
        else                           penalty_o = PEN_CROSS;
    end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int SHORT_W   = 8,
    parameter int PAGE_BITS = 8,
    parameter int ZV_W      = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            resolve_i,
    input  logic            long_i,
    input  logic [3:0]      cond_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] disp_i,
    input  logic [7:0]      n_result_i,
    input  logic [ZV_W-1:0] z_result_i,
    input  logic            v_i,
    input  logic            c_i,
    output logic            valid_o,
    output logic            taken_o,
    output logic [PC_W-1:0] target_o,
    output logic [1:0]      penalty_o
);
    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] target;
        penalty_e        penalty;
    } result_t;

    flags_t   flags;
    logic     cond_take;
    logic     taken_c;
    logic [PC_W-1:0] target_c;
    penalty_e pen_c;
    result_t  res_q;
    logic     valid_q;

    assign flags.sign    = byte_is_negative(n_result_i);
    assign flags.ovf     = v_i;
    assign flags.cry     = c_i;
    assign flags.nonzero = |z_result_i;

    br_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags),
        .take_o  (cond_take)
    );

    // R10: the long form branches regardless of the selector
    assign taken_c = long_i | cond_take;

    br_target_calc #(.PC_W(PC_W), .SHORT_W(SHORT_W)) u_tgt (
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .long_i   (long_i),
        .taken_i  (taken_c),
        .target_o (target_c)
    );

    br_page_cmp #(.PC_W(PC_W), .PAGE_BITS(PAGE_BITS)) u_page (
        .pc_i      (pc_i),
        .target_i  (target_c),
        .taken_i   (taken_c),
        .long_i    (long_i),
        .penalty_o (pen_c)
    );

    // R1, R2, R11: one result register, loaded only on a strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= resolve_i;
            if (resolve_i) begin
                res_q.taken   <= taken_c;
                res_q.target  <= target_c;
                res_q.penalty <= pen_c;
            end
        end
    end

    assign valid_o   = valid_q;
    assign taken_o   = res_q.taken;
    assign target_o  = res_q.target;
    assign penalty_o = res_q.penalty;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
    parameter int PC_W      = 16,
    parameter int PAGE_BITS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            resolve_i,
    input logic            long_i,
    input logic [PC_W-1:0] pc_i,
    input logic            valid_o,
    input logic            taken_o,
    input logic [PC_W-1:0] target_o,
    input logic [1:0]      penalty_o
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        resolve_i |=> valid_o); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !resolve_i |=> !valid_o); // R2

    AST_UNTAKEN_NO_PENALTY: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !taken_o) |-> (penalty_o == 2'd0)); // R4

    AST_UNTAKEN_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        resolve_i ##1 !taken_o |-> (target_o == $past(pc_i))); // R4

    AST_SAME_PAGE_ONE: assert property (@(posedge clk) disable iff (rst)
        (resolve_i && !long_i) ##1 (taken_o && target_o[PC_W-1:PAGE_BITS] == $past(pc_i[PC_W-1:PAGE_BITS]))
        |-> (penalty_o == 2'd1)); // R5

    AST_CROSS_PAGE_TWO: assert property (@(posedge clk) disable iff (rst)
        (resolve_i && !long_i) ##1 (taken_o && target_o[PC_W-1:PAGE_BITS] != $past(pc_i[PC_W-1:PAGE_BITS]))
        |-> (penalty_o == 2'd2)); // R6

    AST_LONG_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (resolve_i && long_i) |=> (taken_o && penalty_o == 2'd0)); // R10

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !resolve_i |=> ($stable(target_o) && $stable(taken_o) && $stable(penalty_o))); // R11
endmodule

bind br_resolve_unit br_resolve_chk #(.PC_W(PC_W), .PAGE_BITS(PAGE_BITS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .resolve_i (resolve_i),
    .long_i    (long_i),
    .pc_i      (pc_i),
    .valid_o   (valid_o),
    .taken_o   (taken_o),
    .target_o  (target_o),
    .penalty_o (penalty_o)
);

// File: tb/br_resolve_unit_tb.sv
module br_resolve_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        resolve_i;
    logic        long_i;
    logic [3:0]  cond_i;
    logic [15:0] pc_i;
    logic [15:0] disp_i;
    logic [7:0]  n_result_i;
    logic [15:0] z_result_i;
    logic        v_i;
    logic        c_i;
    logic        valid_o;
    logic        taken_o;
    logic [15:0] target_o;
    logic [1:0]  penalty_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    br_resolve_unit dut_i (
        .clk(clk), .rst(rst), .resolve_i(resolve_i), .long_i(long_i),
        .cond_i(cond_i), .pc_i(pc_i), .disp_i(disp_i), .n_result_i(n_result_i),
        .z_result_i(z_result_i), .v_i(v_i), .c_i(c_i), .valid_o(valid_o),
        .taken_o(taken_o), .target_o(target_o), .penalty_o(penalty_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  cond;
        logic        lng;
        logic [15:0] pc;
        logic [15:0] disp;
        logic [7:0]  nb;
        logic [15:0] zv;
        logic        v;
        logic        c;
        logic        tk;
        logic [15:0] tgt;
        logic [1:0]  pen;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd7,  4'd0, 1'b0, 16'h1000, 16'h0010, 8'h7F, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1010, 2'd1}, // R7 R5
        '{4'd4,  4'd0, 1'b0, 16'h1000, 16'h0010, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h1000, 2'd0}, // R4
        '{4'd6,  4'd1, 1'b0, 16'h10F0, 16'h0020, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1110, 2'd2}, // R6
        '{4'd7,  4'd2, 1'b0, 16'h2000, 16'h0004, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h2000, 2'd0}, // R7
        '{4'd6,  4'd3, 1'b0, 16'h2000, 16'h00FE, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h1FFE, 2'd2}, // R6 back
        '{4'd3,  4'd4, 1'b0, 16'h3050, 16'h0080, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h2FD0, 2'd2}, // R3 -128
        '{4'd5,  4'd5, 1'b0, 16'h3080, 16'h007F, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h30FF, 2'd1}, // R5 +127
        '{4'd8,  4'd6, 1'b0, 16'h4000, 16'h0005, 8'h00, 16'h0001, 1'b0, 1'b0, 1'b1, 16'h4005, 2'd1}, // R8
        '{4'd8,  4'd6, 1'b0, 16'h4000, 16'h0005, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h4000, 2'd0}, // R8
        '{4'd8,  4'd7, 1'b0, 16'h4000, 16'h0005, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h4005, 2'd1}, // R8
        '{4'd8,  4'd7, 1'b0, 16'h4000, 16'h0005, 8'h00, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h4000, 2'd0}, // R8 high bits
        '{4'd3,  4'd8, 1'b0, 16'h5000, 16'hFF10, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h5010, 2'd1}, // R3 upper ignored
        '{4'd9,  4'd9, 1'b0, 16'h5000, 16'h0010, 8'hFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 16'h5000, 2'd0}, // R9
        '{4'd10, 4'd9, 1'b1, 16'h6000, 16'h8000, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hE000, 2'd0}, // R10
        '{4'd12, 4'd0, 1'b1, 16'hF000, 16'h2000, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1000, 2'd0}, // R12 long wrap
        '{4'd12, 4'd8, 1'b0, 16'hFFF0, 16'h0020, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0010, 2'd2}, // R12
        '{4'd12, 4'd8, 1'b0, 16'h0005, 16'h00F0, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hFFF5, 2'd2}, // R12
        '{4'd7,  4'd5, 1'b0, 16'h7000, 16'h0010, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h7000, 2'd0}  // R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; resolve_i = 1'b0; long_i = 1'b0; cond_i = '0; pc_i = '0;
        disp_i = '0; n_result_i = '0; z_result_i = '0; v_i = 1'b0; c_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", valid_o, 0);
        check("R1 taken", taken_o, 0);
        check("R1 target", target_o, 0);
        check("R1 penalty", penalty_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle valid", valid_o, 0);
        check("R1 idle target", target_o, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            cond_i = VECS[i].cond; long_i = VECS[i].lng; pc_i = VECS[i].pc;
            disp_i = VECS[i].disp; n_result_i = VECS[i].nb; z_result_i = VECS[i].zv;
            v_i = VECS[i].v; c_i = VECS[i].c; resolve_i = 1'b1;
            @(negedge clk);
            resolve_i = 1'b0;
            check({tag, " R2 valid"}, valid_o, 1);
            check({tag, " taken"}, taken_o, VECS[i].tk);
            check({tag, " target"}, target_o, VECS[i].tgt);
            check({tag, " penalty"}, penalty_o, VECS[i].pen);
            // R11: scramble inputs without a strobe
            pc_i = ~pc_i; disp_i = ~disp_i; cond_i = 4'd8; long_i = ~long_i;
            @(negedge clk);
            check({tag, " R2 pulse end"}, valid_o, 0);
            check({tag, " R11 hold target"}, target_o, VECS[i].tgt);
            check({tag, " R11 hold penalty"}, penalty_o, VECS[i].pen);
        end

        // R2: back-to-back strobes give back-to-back results
        cond_i = 4'd8; long_i = 1'b0; pc_i = 16'h8000; disp_i = 16'h0001; resolve_i = 1'b1;
        @(negedge clk);
        check("R2 b2b first", target_o, 16'h8001);
        pc_i = 16'h80FF; disp_i = 16'h0002;
        @(negedge clk);
        resolve_i = 1'b0;
        check("R2 b2b valid", valid_o, 1);
        check("R6 b2b target", target_o, 16'h8101);
        check("R6 b2b penalty", penalty_o, 2);

        // R1: reset after activity clears results
        rst = 1'b1;
        @(negedge clk);
        check("R1 rerst taken", taken_o, 0);
        check("R1 rerst target", target_o, 0);
        check("R1 rerst penalty", penalty_o, 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule